// File: doc/BRIEF.md
# Register-File Coupled 8x8 Multiply Unit

This block is the multiply execution unit of a small 8-bit datapath. It owns a 32-entry by 8-bit register file. A command names one of six multiply forms and two 5-bit register indices. The forms are unsigned, signed, signed-by-unsigned, and fractional versions of each of those three. The unit reads both operands on the issue edge. It forms a 16-bit product during the following cycle and writes it on the next edge into the fixed pair of registers 1 (high byte) and 0 (low byte).

Each form accepts operands only from its own window of the register file. If either index falls outside that window, or the opcode is reserved, the command is refused with an illegal-operand pulse and nothing is written. Operands are captured before the write-back. Registers 0 and 1 may therefore be used as sources, and both indices may name the same register to square it.

A side write port lets the surrounding logic, or a bench, load operands. A side read port exposes any register, so the result pair can be inspected after write-back.

Top module: `mul_rf_unit`

## Requirements
- R1: A legal command accepted at edge E0 raises busy_o after E0. At edge E1 it writes product bits 15..8 to register 1 and bits 7..0 to register 0. After E1, done_o is high for exactly one cycle, and result_o, carry_o and zero_o hold the outcome. No other register changes.
- R2: Opcode 0 (unsigned × unsigned) accepts any index from 0 to 31.
- R3: Opcode 1 (signed × signed, two's complement) is legal only when both indices are in 16..31.
- R4: Opcode 2 (first operand signed, second operand unsigned) is legal only when both indices are in 16..23.
- R5: Opcodes 3, 4 and 5 are the fractional forms of opcodes 0, 1 and 2. They are legal only with both indices in 16..23. The result is the raw 16-bit product shifted left by one, with bit 0 equal to 0.
- R6: carry_o equals bit 15 of the raw product for every opcode. zero_o is high exactly when result_o is zero.
- R7: A command with an out-of-window index, or with opcode 6 or 7, raises illegal_o for one cycle after the edge that sampled it. busy_o stays low, done_o stays low, and no register changes.
- R8: Operands are read at the issue edge. Using register 0 or 1 as a source, or the same index twice (a square), gives the correct product.
- R9: busy_o is high for exactly one cycle per legal command, and cmd_ready_o is low during it. A command presented while busy is dropped: no write, no flag.
- R10: The side write port stores wr_data_i into register wr_idx_i at the clock edge. When that edge is also a write-back edge, the write-back wins for registers 0 and 1, and side writes to other registers still take effect.
- R11: Reset clears all 32 registers and holds busy_o, done_o and illegal_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 3 | Multiply form, 0..5; 6 and 7 are reserved |
| cmd_ra_i | input | 5 | Index of first operand |
| cmd_rb_i | input | 5 | Index of second operand |
| cmd_ready_o | output | 1 | Unit can accept a command |
| busy_o | output | 1 | Product being formed |
| illegal_o | output | 1 | Last sampled command was refused |
| done_o | output | 1 | Write-back just happened |
| result_o | output | 16 | Formatted product of the last write-back |
| carry_o | output | 1 | Raw product bit 15 |
| zero_o | output | 1 | Result is zero |
| wr_en_i | input | 1 | Side write enable |
| wr_idx_i | input | 5 | Side write index |
| wr_data_i | input | 8 | Side write data |
| rd_idx_i | input | 5 | Side read index |
| rd_data_o | output | 8 | Side read data, combinational |

## Verification
Latched operands that were captured at the wrong edge would show up in result_o and on the read port of registers 0 and 1 in the very cycle after write-back. A window check that is off by one would show as illegal_o, or as its absence, one cycle after issue. A busy state that sticks, or that is skipped, appears on busy_o and cmd_ready_o in the first cycle after issue and makes done_o come late or twice. The bench therefore compares the full register file against its model after every command, so that a stray write is caught before the next command is issued.

// File: rtl/mul_rf_pkg.sv
package mul_rf_pkg;
   typedef enum logic [2:0] {
      MUL_UU  = 3'd0,
      MUL_SS  = 3'd1,
      MUL_SU  = 3'd2,
      MUL_FUU = 3'd3,
      MUL_FSS = 3'd4,
      MUL_FSU = 3'd5,
      MUL_RV6 = 3'd6,
      MUL_RV7 = 3'd7
   } mul_op_e;

   function automatic logic op_is_frac(input mul_op_e op);
      return (op == MUL_FUU) || (op == MUL_FSS) || (op == MUL_FSU);
   endfunction

   function automatic logic op_a_signed(input mul_op_e op);
      return (op == MUL_SS) || (op == MUL_SU) || (op == MUL_FSS) || (op == MUL_FSU);
   endfunction

   function automatic logic op_b_signed(input mul_op_e op);
      return (op == MUL_SS) || (op == MUL_FSS);
   endfunction
endpackage

// File: rtl/mul_regfile.sv
module mul_regfile #(
   parameter int DATA_W = 8,
   parameter int NREG   = 32,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [IDX_W-1:0]  ra_idx_i,
   output logic [DATA_W-1:0] ra_data_o,
   input  logic [IDX_W-1:0]  rb_idx_i,
   output logic [DATA_W-1:0] rb_data_o,
   input  logic [IDX_W-1:0]  rs_idx_i,
   output logic [DATA_W-1:0] rs_data_o,
   input  logic              wb_en_i,
   input  logic [DATA_W-1:0] wb_lo_i,
   input  logic [DATA_W-1:0] wb_hi_i,
   input  logic              hw_en_i,
   input  logic [IDX_W-1:0]  hw_idx_i,
   input  logic [DATA_W-1:0] hw_data_i
);
   logic [DATA_W-1:0] mem [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_ent
         if (i < 2) begin : g_pair
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni)
                  mem[i] <= '0;
               else if (wb_en_i)
                  mem[i] <= (i == 0) ? wb_lo_i : wb_hi_i;
               else if (hw_en_i && (int'(hw_idx_i) == i))
                  mem[i] <= hw_data_i;
            end
         end else begin : g_plain
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni)
                  mem[i] <= '0;
               else if (hw_en_i && (int'(hw_idx_i) == i))
                  mem[i] <= hw_data_i;
            end
         end
      end
   endgenerate

   assign ra_data_o = mem[ra_idx_i];
   assign rb_data_o = mem[rb_idx_i];
   assign rs_data_o = mem[rs_idx_i];

   // R1 / R10: write-back reaches the fixed pair even against a side write
   p_wb_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_en_i |=> (mem[0] == $past(wb_lo_i)) && (mem[1] == $past(wb_hi_i)));

   // R10: side write to a register outside the pair always lands
   p_host_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_en_i && (int'(hw_idx_i) > 1)) |=> (mem[$past(hw_idx_i)] == $past(hw_data_i)));
endmodule

// File: rtl/mul_range_chk.sv
module mul_range_chk
   import mul_rf_pkg::*;
#(
   parameter int NREG      = 32,
   parameter int WIDE_LO   = 16,
   parameter int NARROW_LO = 16,
   parameter int NARROW_HI = 23,
   parameter bit FRAC_EN   = 1'b1,
   localparam int IDX_W    = $clog2(NREG)
) (
   input  mul_op_e          op_i,
   input  logic [IDX_W-1:0] ra_i,
   input  logic [IDX_W-1:0] rb_i,
   output logic             legal_o
);
   logic in_any, in_wide, in_narrow, frac_ok;

   assign in_any    = (int'(ra_i) < NREG) && (int'(rb_i) < NREG);
   assign in_wide   = in_any && (int'(ra_i) >= WIDE_LO) && (int'(rb_i) >= WIDE_LO);
   assign in_narrow = (int'(ra_i) >= NARROW_LO) && (int'(ra_i) <= NARROW_HI) &&
                      (int'(rb_i) >= NARROW_LO) && (int'(rb_i) <= NARROW_HI);

   generate
      if (FRAC_EN) begin : g_frac_on
         assign frac_ok = in_narrow;
      end else begin : g_frac_off
         assign frac_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         MUL_UU:                    legal_o = in_any;
         MUL_SS:                    legal_o = in_wide;
         MUL_SU:                    legal_o = in_narrow;
         MUL_FUU, MUL_FSS, MUL_FSU: legal_o = frac_ok;
         default:                   legal_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/mul_prod_fmt.sv
module mul_prod_fmt
   import mul_rf_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit FRAC_EN = 1'b1,
   localparam int PROD_W = 2 * DATA_W
) (
   input  mul_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [PROD_W-1:0] res_o,
   output logic              carry_o,
   output logic              zero_o
);
   logic [PROD_W-1:0] ext_a, ext_b, raw;

   assign ext_a = {{DATA_W{op_a_signed(op_i) & a_i[DATA_W-1]}}, a_i};
   assign ext_b = {{DATA_W{op_b_signed(op_i) & b_i[DATA_W-1]}}, b_i};
   assign raw   = ext_a * ext_b;

   generate
      if (FRAC_EN) begin : g_frac
         assign res_o = op_is_frac(op_i) ? {raw[PROD_W-2:0], 1'b0} : raw;
      end else begin : g_int
         assign res_o = raw;
      end
   endgenerate

   assign carry_o = raw[PROD_W-1];
   assign zero_o  = (res_o == '0);
endmodule

// File: rtl/mul_rf_unit.sv
module mul_rf_unit
   import mul_rf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NREG      = 32,
   parameter int WIDE_LO   = 16,
   parameter int NARROW_LO = 16,
   parameter int NARROW_HI = 23,
   parameter bit FRAC_EN   = 1'b1,
   localparam int IDX_W    = $clog2(NREG),
   localparam int PROD_W   = 2 * DATA_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_op_i,
   input  logic [IDX_W-1:0]  cmd_ra_i,
   input  logic [IDX_W-1:0]  cmd_rb_i,
   output logic              cmd_ready_o,
   output logic              busy_o,
   output logic              illegal_o,
   output logic              done_o,
   output logic [PROD_W-1:0] result_o,
   output logic              carry_o,
   output logic              zero_o,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (NREG < 2) begin : g_bad_n
         $error("NREG must hold the result pair");
      end
      if (!(NARROW_LO <= NARROW_HI && NARROW_HI < NREG && WIDE_LO < NREG)) begin : g_bad_win
         $error("operand windows must lie inside the register file");
      end
   endgenerate

   mul_op_e           cmd_op, op_q, fmt_op;
   logic              legal, fire;
   logic              busy_q, illegal_q, done_q, carry_q, zero_q;
   logic [DATA_W-1:0] rdat_a, rdat_b, opa_q, opb_q;
   logic [PROD_W-1:0] res_q, fmt_res;
   logic              fmt_carry, fmt_zero;

   assign cmd_op = mul_op_e'(cmd_op_i);
   assign fire   = cmd_valid_i && !busy_q;
   assign fmt_op = op_q;

   mul_regfile #(.DATA_W(DATA_W), .NREG(NREG)) i_rf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ra_idx_i  (cmd_ra_i),
      .ra_data_o (rdat_a),
      .rb_idx_i  (cmd_rb_i),
      .rb_data_o (rdat_b),
      .rs_idx_i  (rd_idx_i),
      .rs_data_o (rd_data_o),
      .wb_en_i   (busy_q),
      .wb_lo_i   (fmt_res[DATA_W-1:0]),
      .wb_hi_i   (fmt_res[PROD_W-1:DATA_W]),
      .hw_en_i   (wr_en_i),
      .hw_idx_i  (wr_idx_i),
      .hw_data_i (wr_data_i)
   );

   mul_range_chk #(
      .NREG(NREG), .WIDE_LO(WIDE_LO), .NARROW_LO(NARROW_LO),
      .NARROW_HI(NARROW_HI), .FRAC_EN(FRAC_EN)
   ) i_chk (
      .op_i    (cmd_op),
      .ra_i    (cmd_ra_i),
      .rb_i    (cmd_rb_i),
      .legal_o (legal)
   );

   mul_prod_fmt #(.DATA_W(DATA_W), .FRAC_EN(FRAC_EN)) i_fmt (
      .op_i    (fmt_op),
      .a_i     (opa_q),
      .b_i     (opb_q),
      .res_o   (fmt_res),
      .carry_o (fmt_carry),
      .zero_o  (fmt_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q    <= 1'b0;
         illegal_q <= 1'b0;
         done_q    <= 1'b0;
         op_q      <= MUL_UU;
         opa_q     <= '0;
         opb_q     <= '0;
         res_q     <= '0;
         carry_q   <= 1'b0;
         zero_q    <= 1'b0;
      end else begin
         busy_q    <= fire && legal;
         illegal_q <= fire && !legal;
         done_q    <= busy_q;
         if (fire && legal) begin
            op_q  <= cmd_op;
            opa_q <= rdat_a;
            opb_q <= rdat_b;
         end
         if (busy_q) begin
            res_q   <= fmt_res;
            carry_q <= fmt_carry;
            zero_q  <= fmt_zero;
         end
      end
   end

   assign cmd_ready_o = !busy_q;
   assign busy_o      = busy_q;
   assign illegal_o   = illegal_q;
   assign done_o      = done_q;
   assign result_o    = res_q;
   assign carry_o     = carry_q;
   assign zero_o      = zero_q;

   // R9: busy lasts one cycle and never overlaps a new acceptance
   p_busy_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> !busy_o);

   // R1: done follows busy by exactly one cycle
   p_done_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> done_o);
   p_done_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(busy_o));

   // R7: a refused command never starts a product
   p_illegal_no_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> !busy_o);

   // R5: fractional results have a cleared least significant bit
   p_frac_lsb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && op_is_frac(op_q)) |-> !result_o[0]);

   // R6: the zero flag agrees with the stored result
   p_zero_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (zero_o == (result_o == '0)));
endmodule

// File: tb/test_mul_rf_unit.sv
module test_mul_rf_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [4:0]  cmd_ra = '0, cmd_rb = '0;
   logic        cmd_ready, busy, illegal, done, carry, zero;
   logic [15:0] result;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0, rd_idx = '0;
   logic [7:0]  wr_data = '0, rd_data;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   mul_rf_unit i_mul_rf_unit (
      .clk_i(clk), .rst_ni(rst_n),
      .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_ra_i(cmd_ra), .cmd_rb_i(cmd_rb),
      .cmd_ready_o(cmd_ready), .busy_o(busy), .illegal_o(illegal), .done_o(done),
      .result_o(result), .carry_o(carry), .zero_o(zero),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .rd_idx_i(rd_idx), .rd_data_o(rd_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_legal(input int op, input int ia, input int ib);
      case (op)
         0: return 1'b1;
         1: return ia >= 16 && ib >= 16;
         2, 3, 4, 5: return ia >= 16 && ia <= 23 && ib >= 16 && ib <= 23;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] exp_raw(input int op, input logic [7:0] a, input logic [7:0] b);
      int p;
      case (op)
         1, 4:    p = int'($signed(a)) * int'($signed(b));
         2, 5:    p = int'($signed(a)) * int'(b);
         default: p = int'(a) * int'(b);
      endcase
      return p[15:0];
   endfunction

   task automatic rf_compare(input string req);
      int bad = -1;
      logic [7:0] got = '0;
      for (int i = 0; i < 32; i++) begin
         rd_idx = 5'(i);
         #1;
         if (bad < 0 && rd_data !== model[i]) begin
            bad = i;
            got = rd_data;
         end
      end
      if (bad < 0) chk(1'b1, req, "register file", 0, 0);
      else chk(1'b0, req, $sformatf("register %0d", bad), got, model[bad]);
   endtask

   task automatic host_write(input int idx, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model[idx] = d;
   endtask

   task automatic do_cmd(input int op, input int ia, input int ib, input string req);
      bit lg;
      logic [15:0] raw, res;
      lg  = exp_legal(op, ia, ib);
      raw = exp_raw(op, model[ia], model[ib]);
      res = (op >= 3 && op <= 5) ? {raw[14:0], 1'b0} : raw;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_ra = 5'(ia); cmd_rb = 5'(ib);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == lg, lg ? "R9" : "R7", "busy after issue", busy, lg);
      chk(cmd_ready == !lg, "R9", "ready after issue", cmd_ready, !lg);
      chk(illegal == !lg, lg ? req : "R7", "illegal flag", illegal, !lg);
      @(negedge clk);
      chk(done == lg, lg ? "R1" : "R7", "done pulse", done, lg);
      chk(busy == 1'b0, "R9", "busy cleared", busy, 0);
      if (lg) begin
         chk(result == res, req, $sformatf("result op%0d r%0d r%0d", op, ia, ib), result, res);
         chk(carry == raw[15], "R6", "carry", carry, raw[15]);
         chk(zero == (res == 16'h0), "R6", "zero", zero, res == 16'h0);
         model[0] = res[7:0];
         model[1] = res[15:8];
      end
      rf_compare(lg ? "R1" : "R7");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed;
      for (int i = 0; i < 32; i++) model[i] = '0;
      seed = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && illegal == 0, "R11", "flags in reset", {busy, done, illegal}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rf_compare("R11");
      chk(cmd_ready == 1, "R11", "ready after reset", cmd_ready, 1);

      // directed corners
      host_write(0, 8'd13);
      do_cmd(0, 0, 0, "R8");                 // square of register 0 into its own pair
      host_write(0, 8'd200); host_write(1, 8'd7);
      do_cmd(0, 1, 0, "R8");                 // both sources inside the destination pair
      do_cmd(0, 31, 2, "R2");                // wide window corner
      host_write(16, 8'h80); host_write(31, 8'h80);
      do_cmd(1, 16, 31, "R3");               // -128 * -128
      host_write(17, 8'hFF); host_write(23, 8'hFF);
      do_cmd(2, 17, 23, "R4");               // -1 * 255
      do_cmd(3, 17, 23, "R5");               // 0xFF*0xFF fractional, carry set
      do_cmd(4, 16, 16, "R5");               // -1.0 * -1.0 fractional
      do_cmd(5, 16, 17, "R5");
      host_write(18, 8'h00);
      do_cmd(1, 18, 31, "R6");               // zero result
      do_cmd(1, 15, 16, "R7");               // below signed window
      do_cmd(2, 16, 24, "R7");               // above narrow window
      do_cmd(5, 23, 24, "R7");
      do_cmd(6, 16, 17, "R7");               // reserved opcodes
      do_cmd(7, 20, 20, "R7");

      // R9: second command while busy is dropped
      host_write(19, 8'd3); host_write(20, 8'd5); host_write(21, 8'd9);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_ra = 5'd19; cmd_rb = 5'd20;
      @(negedge clk);
      cmd_ra = 5'd21; cmd_rb = 5'd21;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(done == 1 && result == 16'd15, "R9", "first command result", result, 15);
      @(negedge clk);
      chk(done == 0 && busy == 0 && illegal == 0, "R9", "refused command silent",
          {done, busy, illegal}, 0);
      model[0] = 8'd15; model[1] = 8'd0;
      rf_compare("R9");

      // R10: side write on the write-back edge
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_ra = 5'd20; cmd_rb = 5'd21;
      @(negedge clk);
      cmd_valid = 1'b0;
      wr_en = 1'b1; wr_idx = 5'd0; wr_data = 8'hAA;
      @(negedge clk);
      wr_en = 1'b0;
      model[0] = 8'd45; model[1] = 8'd0;
      rf_compare("R10");
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_ra = 5'd19; cmd_rb = 5'd21;
      @(negedge clk);
      cmd_valid = 1'b0;
      wr_en = 1'b1; wr_idx = 5'd5; wr_data = 8'h5C;
      @(negedge clk);
      wr_en = 1'b0;
      model[0] = 8'd27; model[1] = 8'd0; model[5] = 8'h5C;
      rf_compare("R10");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 4 == 0) begin
            host_write(int'($urandom % 32), 8'($urandom));
         end else begin
            int op, ia, ib, sel;
            op  = int'($urandom % 8);
            sel = int'($urandom % 4);
            ia  = (sel == 0) ? int'($urandom % 32) : (sel == 1) ? 16 + int'($urandom % 8) :
                  (sel == 2) ? 16 + int'($urandom % 16) : int'($urandom % 2);
            ib  = (sel == 0) ? int'($urandom % 32) : (sel == 1) ? 16 + int'($urandom % 8) :
                  (sel == 2) ? 16 + int'($urandom % 16) : int'($urandom % 2);
            do_cmd(op, ia, ib, (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5");
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule